// File: doc/BRIEF.md
# Debug Monitor Entry Qualifier and Single-Pin Serial Link

When power-on reset ends, this block fetches the two bytes of the reset vector through a simple synchronous read port. It also samples a three-level condition on the interrupt pin. From these it decides whether the device comes up in debug monitor mode and which clock source the monitor uses. The decision and the clock choice are held until the next power-on reset.

While the monitor is active, the block runs a half-duplex NRZ byte link on one shared line. The line has an external pullup, so the block only pulls it low or lets it go. A free-running bit-rate tick paces the transmitter. The receiver times its own sampling from each start edge and ignores the line while the block is transmitting. Command decoding, memory programming and security are handled by other logic.

Top module: `mon_link_top`

## Requirements
- R1: The vector counts as erased only when the byte at the top address (all ones) and the byte at the address one below both read FFh. The read port returns data one clock after `rd_en` with `rd_addr`.
- R2: The `irq_level` encoding is 00 = logic low, 01 = logic high, 10 = high test voltage and 11 = reserved. Test voltage enters the monitor on the external clock (`clk_sel` = 0) whatever the vector holds.
- R3: An erased vector with `irq_level` = 01 enters the monitor on the external clock (`mon_active` = 1, `clk_sel` = 0).
- R4: An erased vector with `irq_level` = 00 enters the monitor on the internal clock (`clk_sel` = 1). `clk_sel` is never 1 outside the monitor.
- R5: Every other combination leaves normal mode with `mon_active` = 0 and `clk_sel` = 0. In normal mode the line is never pulled, `bit_tick` stays low, `tx_start` is ignored and received frames produce no `rx_valid`.
- R6: The entry decision is taken only after reset. `mon_active` and `clk_sel` hold while `irq_level` and memory contents change.
- R7: While the monitor is active, `bit_tick` pulses for one clock every `BIT_CLKS` clocks.
- R8: A transmitted frame is a low start bit, eight data bits sent LSB first, and a released stop bit. Each bit lasts `BIT_CLKS` clocks. A 0 bit pulls the line low and a 1 bit releases it. `tx_busy` covers the whole frame.
- R9: The receiver samples each bit near its middle. It presents the byte on `rx_data` with a one-clock `rx_valid` pulse.
- R10: While `tx_busy` is high, the receiver ignores the line, so the block's own frames are not received.
- R11: A frame whose stop bit reads low is discarded. The receiver then waits for the line to go high, and the next frame is received normally.
- R12: While `rst` is high, `mon_active`, `clk_sel`, `pin_pull_low`, `tx_busy` and `rx_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| rd_en | output | 1 | Read strobe for a vector byte |
| rd_addr | output | ADDR_W | Address of the vector byte being read |
| rd_data | input | 8 | Read data, valid one clock after `rd_en` |
| irq_level | input | 2 | Interrupt pin condition: 00 low, 01 high, 10 test voltage, 11 reserved |
| mon_active | output | 1 | Monitor mode entered |
| clk_sel | output | 1 | 1 = internal clock, 0 = external clock |
| entry_done | output | 1 | Entry decision is final |
| bit_tick | output | 1 | One-clock pulse per bit period |
| pin_in | input | 1 | Level of the shared line |
| pin_pull_low | output | 1 | 1 pulls the shared line low, 0 releases it |
| tx_data | input | 8 | Byte to send |
| tx_start | input | 1 | Start a frame with `tx_data` |
| tx_busy | output | 1 | Frame in progress |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-clock pulse when `rx_data` is new |

## Verification
The bench builds the block with `BIT_CLKS` = 16, which cuts a frame to 160 clocks. With this value, many transmit and receive frames and whole tick periods fit in a short run. `ADDR_W` stays at 16, so the vector bytes sit at FFFEh and FFFFh and the read-port decode is exercised at its real width. Every row of the entry-condition table is reached by reapplying reset, so each vector and interrupt-pin pairing is checked on its own.

// File: rtl/mon_pkg.sv
package mon_pkg;

    localparam logic [7:0] ERASED_BYTE = 8'hFF;

    typedef enum logic [1:0] {
        IRQ_LOW  = 2'b00,
        IRQ_HIGH = 2'b01,
        IRQ_TEST = 2'b10,
        IRQ_RSVD = 2'b11
    } irq_lvl_e;

    typedef struct packed {
        logic active;
        logic clk_int;
    } mon_cfg_t;

    typedef enum logic [1:0] {
        ENT_RD_LO,
        ENT_RD_HI,
        ENT_DECIDE,
        ENT_DONE
    } ent_state_e;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_WAIT,
        TX_SHIFT
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_HOLD
    } rx_state_e;

    function automatic mon_cfg_t decide_entry(input logic erased, input irq_lvl_e lvl);
        mon_cfg_t c;
        c = '0;
        case (lvl)
            IRQ_TEST: c.active = 1'b1;
            IRQ_HIGH: c.active = erased;
            IRQ_LOW: begin
                c.active  = erased;
                c.clk_int = erased;
            end
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/mon_entry.sv
module mon_entry
    import mon_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data,
    input  logic [1:0]        irq_level,
    output mon_cfg_t          cfg,
    output logic              done
);
    localparam logic [ADDR_W-1:0] VEC_TOP = '1;
    localparam logic [ADDR_W-1:0] VEC_LOW = VEC_TOP - 1'b1;

    ent_state_e st;
    logic [7:0] low_byte;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ENT_RD_LO;
            low_byte <= '0;
            cfg      <= '0;
        end else begin
            case (st)
                ENT_RD_LO: st <= ENT_RD_HI;
                ENT_RD_HI: begin
                    low_byte <= rd_data;
                    st       <= ENT_DECIDE;
                end
                ENT_DECIDE: begin
                    cfg <= decide_entry((low_byte == ERASED_BYTE) && (rd_data == ERASED_BYTE),
                                        irq_lvl_e'(irq_level));
                    st  <= ENT_DONE;
                end
                default: st <= ENT_DONE;
            endcase
        end
    end

    assign rd_en   = (st == ENT_RD_LO) || (st == ENT_RD_HI);
    assign rd_addr = (st == ENT_RD_LO) ? VEC_LOW : VEC_TOP;
    assign done    = (st == ENT_DONE);

    AST_FLAGS_LATCHED: assert property (@(posedge clk) disable iff (rst)
        (done && $past(done)) |-> ($stable(cfg.active) && $stable(cfg.clk_int))); // R6
    AST_NO_READ_AFTER_DECISION: assert property (@(posedge clk) disable iff (rst)
        $past(done) |-> !rd_en); // R1

endmodule

// File: rtl/mon_baud.sv
module mon_baud #(
    parameter int BIT_CLKS = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);
    localparam int CNT_W = (BIT_CLKS > 2) ? $clog2(BIT_CLKS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BIT_CLKS - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = en && (cnt == LAST);

    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick); // R7

endmodule

// File: rtl/mon_tx.sv
module mon_tx
    import mon_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       tick,
    input  logic       start,
    input  logic [7:0] data,
    output logic       busy,
    output logic       pull_low
);
    tx_state_e  st;
    logic [3:0] idx;
    logic [7:0] shreg;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            st    <= TX_IDLE;
            idx   <= '0;
            shreg <= '0;
        end else begin
            case (st)
                TX_IDLE: begin
                    if (start) begin
                        shreg <= data;
                        st    <= TX_WAIT;
                    end
                end
                TX_WAIT: begin
                    if (tick) begin
                        idx <= '0;
                        st  <= TX_SHIFT;
                    end
                end
                default: begin
                    if (tick) begin
                        if (idx >= 4'd1 && idx <= 4'd8) shreg <= {1'b0, shreg[7:1]};
                        if (idx == 4'd9) st <= TX_IDLE;
                        else idx <= idx + 1'b1;
                    end
                end
            endcase
        end
    end

    assign busy     = (st != TX_IDLE);
    assign pull_low = (st == TX_SHIFT) && ((idx == 4'd0) || ((idx <= 4'd8) && !shreg[0]));

    AST_BIT_HELD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (rst)
        ((st == TX_SHIFT) && $past(st == TX_SHIFT) && !$past(tick)) |-> $stable(idx)); // R8

endmodule

// File: rtl/mon_rx.sv
module mon_rx
    import mon_pkg::*;
#(
    parameter int BIT_CLKS = 256
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       mute,
    input  logic       pin,
    output logic [7:0] data,
    output logic       valid
);
    localparam int CNT_W = (BIT_CLKS > 2) ? $clog2(BIT_CLKS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BIT_CLKS - 1);
    localparam logic [CNT_W-1:0] HALF = CNT_W'(BIT_CLKS / 2 - 1);

    rx_state_e        st;
    logic [CNT_W-1:0] cnt;
    logic [2:0]       bitn;
    logic [7:0]       shreg;
    logic             s1, line;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1   <= 1'b1;
            line <= 1'b1;
        end else begin
            s1   <= pin;
            line <= s1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= RX_IDLE;
            cnt   <= '0;
            bitn  <= '0;
            shreg <= '0;
            data  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (!en || mute) begin
                st <= RX_IDLE;
            end else begin
                case (st)
                    RX_IDLE: begin
                        if (!line) begin
                            cnt <= '0;
                            st  <= RX_START;
                        end
                    end
                    RX_START: begin
                        if (cnt == HALF) begin
                            cnt  <= '0;
                            bitn <= '0;
                            st   <= line ? RX_IDLE : RX_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (cnt == LAST) begin
                            cnt   <= '0;
                            shreg <= {line, shreg[7:1]};
                            if (bitn == 3'd7) st <= RX_STOP;
                            else bitn <= bitn + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (cnt == LAST) begin
                            cnt <= '0;
                            if (line) begin
                                data  <= shreg;
                                valid <= 1'b1;
                                st    <= RX_IDLE;
                            end else begin
                                st <= RX_HOLD;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: begin
                        if (line) st <= RX_IDLE;
                    end
                endcase
            end
        end
    end

    AST_RX_MUTED: assert property (@(posedge clk) disable iff (rst)
        $past(mute) |-> !valid); // R10
    AST_RX_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid); // R9

endmodule

// File: rtl/mon_link_top.sv
module mon_link_top
    import mon_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int BIT_CLKS = 256
) (
    input  logic              clk,
    input  logic              rst,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data,
    input  logic [1:0]        irq_level,
    output logic              mon_active,
    output logic              clk_sel,
    output logic              entry_done,
    output logic              bit_tick,
    input  logic              pin_in,
    output logic              pin_pull_low,
    input  logic [7:0]        tx_data,
    input  logic              tx_start,
    output logic              tx_busy,
    output logic [7:0]        rx_data,
    output logic              rx_valid
);
    mon_cfg_t cfg;

    mon_entry #(.ADDR_W(ADDR_W)) u_entry (
        .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .irq_level(irq_level), .cfg(cfg), .done(entry_done)
    );

    assign mon_active = cfg.active;
    assign clk_sel    = cfg.clk_int;

    mon_baud #(.BIT_CLKS(BIT_CLKS)) u_baud (
        .clk(clk), .rst(rst), .en(cfg.active), .tick(bit_tick)
    );

    mon_tx u_tx (
        .clk(clk), .rst(rst), .en(cfg.active), .tick(bit_tick), .start(tx_start),
        .data(tx_data), .busy(tx_busy), .pull_low(pin_pull_low)
    );

    mon_rx #(.BIT_CLKS(BIT_CLKS)) u_rx (
        .clk(clk), .rst(rst), .en(cfg.active), .mute(tx_busy), .pin(pin_in),
        .data(rx_data), .valid(rx_valid)
    );

    AST_NORMAL_PIN_RELEASED: assert property (@(posedge clk) disable iff (rst)
        !mon_active |-> !pin_pull_low); // R5
    AST_INT_CLK_ONLY_IN_MON: assert property (@(posedge clk) disable iff (rst)
        clk_sel |-> mon_active); // R4

endmodule

// File: tb/mon_link_top_test.sv
module mon_link_top_test;
    localparam int BC = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_en;
    logic [15:0] rd_addr;
    logic [7:0]  rd_data = '0;
    logic [1:0]  irq_level = 2'b01;
    logic        mon_active, clk_sel, entry_done, bit_tick;
    logic        pin_pull_low, tx_busy, rx_valid;
    logic [7:0]  tx_data = '0;
    logic        tx_start = 1'b0;
    logic [7:0]  rx_data;
    logic        host_pull = 1'b0;
    logic        pin;
    logic [7:0]  mem_lo = 8'hFF, mem_hi = 8'hFF;

    int checks = 0, fails = 0;
    int rx_cnt = 0, tick_cnt = 0;
    logic [7:0] rx_last = '0;
    bit finished = 0;

    always #5 clk = ~clk;

    assign pin = !(pin_pull_low | host_pull);

    mon_link_top #(.ADDR_W(16), .BIT_CLKS(BC)) uut (
        .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .irq_level(irq_level), .mon_active(mon_active), .clk_sel(clk_sel),
        .entry_done(entry_done), .bit_tick(bit_tick), .pin_in(pin),
        .pin_pull_low(pin_pull_low), .tx_data(tx_data), .tx_start(tx_start),
        .tx_busy(tx_busy), .rx_data(rx_data), .rx_valid(rx_valid)
    );

    always @(posedge clk) begin
        if (rd_en)
            rd_data <= (rd_addr == 16'hFFFE) ? mem_lo :
                       (rd_addr == 16'hFFFF) ? mem_hi : 8'h00;
        if (rx_valid) begin
            rx_cnt  <= rx_cnt + 1;
            rx_last <= rx_data;
        end
        if (bit_tick) tick_cnt <= tick_cnt + 1;
    end

    // lo[19:12] hi[11:4] irq[3:2] active[1] clk_int[0]
    localparam logic [19:0] VEC [10] = '{
        {8'hFF, 8'hFF, 2'b01, 1'b1, 1'b0},  // R3
        {8'hFF, 8'hFF, 2'b00, 1'b1, 1'b1},  // R4
        {8'hFF, 8'hFF, 2'b10, 1'b1, 1'b0},  // R2
        {8'hFF, 8'hFF, 2'b11, 1'b0, 1'b0},  // R5
        {8'h12, 8'h34, 2'b10, 1'b1, 1'b0},  // R2
        {8'h12, 8'h34, 2'b01, 1'b0, 1'b0},  // R5
        {8'h12, 8'h34, 2'b00, 1'b0, 1'b0},  // R5
        {8'hFF, 8'h7F, 2'b00, 1'b0, 1'b0},  // R1
        {8'hFE, 8'hFF, 2'b01, 1'b0, 1'b0},  // R1
        {8'h00, 8'hFF, 2'b10, 1'b1, 1'b0}   // R2
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic host_send(input logic [7:0] b, input bit stop_ok);
        @(negedge clk);
        host_pull = 1'b1;
        repeat (BC) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            host_pull = !b[i];
            repeat (BC) @(negedge clk);
        end
        host_pull = !stop_ok;
        repeat (BC) @(negedge clk);
        host_pull = 1'b0;
        repeat (BC + 8) @(negedge clk);
    endtask

    task automatic send_and_decode(input logic [7:0] b, input string req);
        logic [7:0] got;
        logic       st_bit, sp_bit;
        int         rx_before;
        rx_before = rx_cnt;
        got = '0;
        @(negedge clk);
        tx_data  = b;
        tx_start = 1'b1;
        @(negedge clk);
        tx_start = 1'b0;
        for (int i = 0; i < 200 && pin; i++) @(negedge clk);
        repeat (BC / 2) @(negedge clk);
        st_bit = pin;
        for (int i = 0; i < 8; i++) begin
            repeat (BC) @(negedge clk);
            got[i] = pin;
        end
        repeat (BC) @(negedge clk);
        sp_bit = pin;
        repeat (BC) @(negedge clk);
        chk(st_bit == 1'b0, {req, " start bit low"}, st_bit, 0);
        chk(got == b, {req, " data LSB first"}, got, b);
        chk(sp_bit == 1'b1, {req, " stop bit released"}, sp_bit, 1);
        chk(tx_busy == 1'b0, {req, " busy clears after frame"}, tx_busy, 0);
        chk(rx_cnt == rx_before, "R10 own frame not received", rx_cnt, rx_before);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int t0;
        int r0;

        // R12 reset state
        repeat (3) @(negedge clk);
        chk(!mon_active && !clk_sel && !pin_pull_low && !tx_busy && !rx_valid, "R12 reset outputs",
            {mon_active, clk_sel, pin_pull_low, tx_busy, rx_valid}, 0);

        // entry table
        for (int v = 0; v < 10; v++) begin
            mem_lo    = VEC[v][19:12];
            mem_hi    = VEC[v][11:4];
            irq_level = VEC[v][3:2];
            do_reset();
            chk({mon_active, clk_sel} == VEC[v][1:0], $sformatf("R1/R2/R3/R4/R5 entry row %0d", v),
                {mon_active, clk_sel}, VEC[v][1:0]);
        end

        // R6 latching: erased + low -> internal clock, then disturb inputs
        mem_lo = 8'hFF; mem_hi = 8'hFF; irq_level = 2'b00;
        do_reset();
        chk(mon_active && clk_sel, "R4 internal clock entry", {mon_active, clk_sel}, 3);
        irq_level = 2'b11; mem_lo = 8'h00; mem_hi = 8'h00;
        repeat (40) @(negedge clk);
        chk(mon_active && clk_sel, "R6 flags held after inputs change", {mon_active, clk_sel}, 3);

        // R7 tick rate
        t0 = tick_cnt;
        repeat (10 * BC) @(negedge clk);
        chk(tick_cnt - t0 == 10, "R7 ticks per 10 bit periods", tick_cnt - t0, 10);
        while (!bit_tick) @(negedge clk);
        t0 = 0;
        @(negedge clk);
        t0++;
        while (!bit_tick) begin
            @(negedge clk);
            t0++;
        end
        chk(t0 == BC, "R7 tick spacing", t0, BC);

        // R8 / R10 transmit
        send_and_decode(8'hA5, "R8");
        send_and_decode(8'h01, "R8");
        send_and_decode(8'hFE, "R8");

        // R9 receive
        r0 = rx_cnt;
        host_send(8'h3C, 1'b1);
        chk(rx_cnt == r0 + 1 && rx_last == 8'h3C, "R9 receive 3C", rx_last, 8'h3C);
        host_send(8'h81, 1'b1);
        chk(rx_cnt == r0 + 2 && rx_last == 8'h81, "R9 receive 81", rx_last, 8'h81);

        // R11 bad stop discarded, then recovery
        r0 = rx_cnt;
        host_send(8'h55, 1'b0);
        chk(rx_cnt == r0, "R11 bad stop discarded", rx_cnt, r0);
        host_send(8'h96, 1'b1);
        chk(rx_cnt == r0 + 1 && rx_last == 8'h96, "R11 recovery frame", rx_last, 8'h96);

        // R5 normal mode: link silent
        mem_lo = 8'h12; mem_hi = 8'h34; irq_level = 2'b00;
        do_reset();
        chk(!mon_active && !clk_sel, "R5 normal mode flags", {mon_active, clk_sel}, 0);
        t0 = tick_cnt;
        r0 = rx_cnt;
        @(negedge clk);
        tx_data  = 8'h00;
        tx_start = 1'b1;
        @(negedge clk);
        tx_start = 1'b0;
        begin
            bit seen_low;
            seen_low = 0;
            for (int i = 0; i < 12 * BC; i++) begin
                @(negedge clk);
                if (pin_pull_low || tx_busy) seen_low = 1;
            end
            chk(!seen_low, "R5 tx_start ignored in normal mode", seen_low, 0);
        end
        chk(tick_cnt == t0, "R5 no tick in normal mode", tick_cnt - t0, 0);
        host_send(8'h42, 1'b1);
        chk(rx_cnt == r0, "R5 no receive in normal mode", rx_cnt, r0);

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule